// File: doc/BRIEF.md
# UART Flow Control and Driver-Enable Gate

This block sits beside a UART transmitter and receiver and decides when the transmitter may begin a character. It also decides what the shared request/enable pin shows. The clear-to-send input is active low and asynchronous. It is synchronized, and while CTS gating is on, a new character may begin only while the synchronized level is low. The transmitter reports a character in flight on `tx_busy`. The block never interrupts a character that is in flight: CTS only gates the start of the next one. Data that becomes pending while CTS is high waits, and it is released once CTS returns low.

The shared pin has two roles. In request-to-send mode it is an active-low output that is driven low only while the receive side reports room. In driver-enable mode it follows the transmitter's in-flight indication, for an external RS-485 transceiver, with a selectable polarity. Every edge of the synchronized CTS level sets a sticky change flag, and that flag is masked into an interrupt output.

Top module: `uart_flow_gate`

## Requirements
- R1: With `cts_en`=1, `tx_start_ok` is 1 only when the synchronized CTS level is 0. The synchronized level is `cts_n_pin` delayed by two clock edges.
- R2: `tx_start_ok` is 0 whenever `tx_busy` is 1. A character in flight is never affected by CTS: with `de_en`=1, the pin keeps tracking `tx_busy` while CTS toggles.
- R3: If `tx_pending`=1 while CTS is high, the start is held off. `tx_start_ok` rises in the second cycle after `cts_n_pin` falls.
- R4: With `de_en`=0 and `rts_en`=1, `rts_de_pin` equals the inverse of `rx_space` one clock edge earlier. It is 0 when there is room.
- R5: With `de_en`=1, `rts_de_pin` equals `tx_busy` XOR `de_pol_low` one clock edge earlier. `de_pol_low`=0 gives an active-high enable and 1 gives an active-low enable.
- R6: With `cts_en`=0, `tx_start_ok` = `tx_pending` AND NOT `tx_busy`. With `de_en`=0 and `rts_en`=0, `rts_de_pin` is 0.
- R7: `cts_chg_flag` is set on every rise or fall of the synchronized CTS level, three edges after the pin changes. It stays set until `cts_chg_clr` is pulsed. A set in the same cycle as a clear wins.
- R8: `cts_irq` = `cts_chg_flag` AND `cts_irq_en`.
- R9: After reset, `rts_de_pin`=0 and `cts_chg_flag`=0. The synchronized CTS level resets to the high (deasserted) state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_pin | input | 1 | Asynchronous active-low clear-to-send input |
| cts_en | input | 1 | Enable CTS start gating |
| rts_en | input | 1 | Enable RTS driven from receive room |
| de_en | input | 1 | Pin carries driver enable instead of RTS |
| de_pol_low | input | 1 | Driver enable active low when 1 |
| cts_irq_en | input | 1 | CTS change interrupt enable |
| cts_chg_clr | input | 1 | Clears the CTS change flag |
| tx_pending | input | 1 | Transmit data waiting |
| tx_busy | input | 1 | Character in flight, start bit through stop bit |
| rx_space | input | 1 | Receive buffer has room |
| tx_start_ok | output | 1 | Permission to start a character |
| rts_de_pin | output | 1 | RTS or driver-enable pin level |
| cts_chg_flag | output | 1 | Sticky CTS change flag |
| cts_irq | output | 1 | CTS change interrupt |

## Verification
The bench drives CTS low just after pending data has been waiting, then checks that permission appears exactly two cycles later. A design that skipped the synchronizer, or added a stage, would start a cycle early or late. CTS is toggled while a character is in flight, in both driver-enable polarities. A design that cut the character short, or tied the pin to CTS, would drop the enable mid-character. Clear pulses are made to coincide with fresh CTS edges, which exposes a design where the clear beats the set. The bench also covers both edge directions, including a rise back to high, to catch a detector that only sees falling edges.

// File: rtl/flow_gate_pkg.sv
package flow_gate_pkg;

    typedef enum logic {
        PIN_AS_RTS = 1'b0,
        PIN_AS_DE  = 1'b1
    } pin_role_e;

    typedef struct packed {
        logic level;
        logic changed;
    } cts_view_t;

    function automatic logic shared_pin_level(
        input pin_role_e role,
        input logic      in_flight,
        input logic      invert_de,
        input logic      rts_on,
        input logic      room
    );
        if (role == PIN_AS_DE)
            return in_flight ^ invert_de;
        else if (rts_on)
            return ~room;
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/cts_sync_edge.sv
module cts_sync_edge
    import flow_gate_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_n,
    input  logic      clr,
    output cts_view_t view
);
    logic [STAGES-1:0] chain;
    logic              last_level;
    logic              flag_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            last_level <= 1'b1;
            flag_q     <= 1'b0;
        end else begin
            last_level <= chain[STAGES-1];
            flag_q     <= (chain[STAGES-1] != last_level) | (flag_q & ~clr);
        end
    end

    assign view.level   = chain[STAGES-1];
    assign view.changed = flag_q;
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate (
    input  logic gate_on,
    input  logic cts_level,
    input  logic pending,
    input  logic busy,
    output logic start_ok
);
    logic cts_allows;

    always_comb begin
        cts_allows = ~gate_on | ~cts_level;
        start_ok   = pending & ~busy & cts_allows;
    end
endmodule

// File: rtl/shared_pin_drv.sv
module shared_pin_drv
    import flow_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic de_mode,
    input  logic de_inv,
    input  logic rts_on,
    input  logic in_flight,
    input  logic room,
    output logic pin
);
    pin_role_e role;
    logic      next_level;

    always_comb begin
        role       = de_mode ? PIN_AS_DE : PIN_AS_RTS;
        next_level = shared_pin_level(role, in_flight, de_inv, rts_on, room);
    end

    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= next_level;
    end
endmodule

// File: rtl/uart_flow_gate.sv
module uart_flow_gate
    import flow_gate_pkg::*;
#(
    parameter int CTS_SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cts_n_pin,
    input  logic cts_en,
    input  logic rts_en,
    input  logic de_en,
    input  logic de_pol_low,
    input  logic cts_irq_en,
    input  logic cts_chg_clr,
    input  logic tx_pending,
    input  logic tx_busy,
    input  logic rx_space,
    output logic tx_start_ok,
    output logic rts_de_pin,
    output logic cts_chg_flag,
    output logic cts_irq
);
    cts_view_t cts_view;
    logic      cts_level;

    cts_sync_edge #(.STAGES(CTS_SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (cts_n_pin),
        .clr   (cts_chg_clr),
        .view  (cts_view)
    );

    assign cts_level    = cts_view.level;
    assign cts_chg_flag = cts_view.changed;
    assign cts_irq      = cts_view.changed & cts_irq_en;

    tx_start_gate u_gate (
        .gate_on   (cts_en),
        .cts_level (cts_level),
        .pending   (tx_pending),
        .busy      (tx_busy),
        .start_ok  (tx_start_ok)
    );

    shared_pin_drv u_pin (
        .clk       (clk),
        .rst       (rst),
        .de_mode   (de_en),
        .de_inv    (de_pol_low),
        .rts_on    (rts_en),
        .in_flight (tx_busy),
        .room      (rx_space),
        .pin       (rts_de_pin)
    );
endmodule

// File: rtl/flow_gate_chk.sv
module flow_gate_chk (
    input logic clk,
    input logic rst,
    input logic cts_level,
    input logic cts_en,
    input logic rts_en,
    input logic de_en,
    input logic de_pol_low,
    input logic cts_irq_en,
    input logic tx_pending,
    input logic tx_busy,
    input logic rx_space,
    input logic tx_start_ok,
    input logic rts_de_pin,
    input logic cts_irq
);
    // R1
    cts_high_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (cts_en && cts_level) |-> !tx_start_ok);

    // R2
    busy_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> !tx_start_ok);

    // R4
    rts_follows_room_chk: assert property (@(posedge clk) disable iff (rst)
        (!de_en && rts_en) |=> (rts_de_pin == !$past(rx_space)));

    // R5
    de_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
        de_en |=> (rts_de_pin == ($past(tx_busy) ^ $past(de_pol_low))));

    // R6
    no_gate_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!cts_en && tx_pending && !tx_busy) |-> tx_start_ok);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !cts_irq_en |-> !cts_irq);
endmodule

bind uart_flow_gate flow_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cts_level   (cts_level),
    .cts_en      (cts_en),
    .rts_en      (rts_en),
    .de_en       (de_en),
    .de_pol_low  (de_pol_low),
    .cts_irq_en  (cts_irq_en),
    .tx_pending  (tx_pending),
    .tx_busy     (tx_busy),
    .rx_space    (rx_space),
    .tx_start_ok (tx_start_ok),
    .rts_de_pin  (rts_de_pin),
    .cts_irq     (cts_irq)
);

// File: tb/tb_uart_flow_gate.sv
module tb_uart_flow_gate;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cts_n_pin = 1'b1, cts_en = 1'b0, rts_en = 1'b0, de_en = 1'b0;
    logic de_pol_low = 1'b0, cts_irq_en = 1'b0, cts_chg_clr = 1'b0;
    logic tx_pending = 1'b0, tx_busy = 1'b0, rx_space = 1'b0;
    logic tx_start_ok, rts_de_pin, cts_chg_flag, cts_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    uart_flow_gate dut (
        .clk(clk), .rst(rst), .cts_n_pin(cts_n_pin), .cts_en(cts_en),
        .rts_en(rts_en), .de_en(de_en), .de_pol_low(de_pol_low),
        .cts_irq_en(cts_irq_en), .cts_chg_clr(cts_chg_clr),
        .tx_pending(tx_pending), .tx_busy(tx_busy), .rx_space(rx_space),
        .tx_start_ok(tx_start_ok), .rts_de_pin(rts_de_pin),
        .cts_chg_flag(cts_chg_flag), .cts_irq(cts_irq)
    );

    // Reference model: history of sampled CTS pin values, newest first
    bit hist [4];
    bit m_flag;
    bit m_pin;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) hist[i] = 1'b1;
            m_flag = 1'b0;
            m_pin  = 1'b0;
        end else begin
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = cts_n_pin;
            // the synchronized level seen one edge ago differed from the one before it
            m_flag = (hist[2] != hist[3]) || (m_flag && !cts_chg_clr);
            if (de_en)       m_pin = tx_busy ^ de_pol_low;
            else if (rts_en) m_pin = !rx_space;
            else             m_pin = 1'b0;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit lvl;
        bit exp_ok;
        lvl    = hist[1];
        exp_ok = tx_pending && !tx_busy && (!cts_en || !lvl);
        chk(tx_start_ok, exp_ok, cts_en ? "R1 R2 start permission" : "R6 R2 start permission");
        chk(rts_de_pin, m_pin, de_en ? "R5 driver enable pin" : (rts_en ? "R4 rts pin" : "R6 idle rts pin"));
        chk(cts_chg_flag, m_flag, "R7 change flag");
        chk(cts_irq, m_flag && cts_irq_en, "R8 interrupt");
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(rts_de_pin, 1'b0, "R9 reset pin");
        chk(cts_chg_flag, 1'b0, "R9 reset flag");
        chk(tx_start_ok, 1'b0, "R9 reset permission");
        rst = 1'b0;

        // R3 directed: pending data waits for CTS low, released two cycles later
        cts_en = 1'b1; tx_pending = 1'b1; cts_n_pin = 1'b1;
        repeat (4) begin step(); chk(tx_start_ok, 1'b0, "R3 held while CTS high"); end
        cts_n_pin = 1'b0;
        step(); chk(tx_start_ok, 1'b0, "R3 first cycle after CTS low");
        step(); chk(tx_start_ok, 1'b1, "R3 second cycle after CTS low");
        step(); chk(cts_chg_flag, 1'b1, "R7 fall sets flag");
        cts_chg_clr = 1'b1; step(); cts_chg_clr = 1'b0;
        step(); chk(cts_chg_flag, 1'b0, "R7 clear");

        // R2 directed: CTS toggles mid-character, active-low driver enable holds
        de_en = 1'b1; de_pol_low = 1'b1; tx_busy = 1'b1;
        step();
        cts_n_pin = 1'b1;
        repeat (5) begin step(); chk(rts_de_pin, 1'b0, "R2 R5 enable held mid-character"); end
        tx_busy = 1'b0;
        step(); step(); chk(rts_de_pin, 1'b1, "R5 active-low idle");
        chk(cts_chg_flag, 1'b1, "R7 rise sets flag");

        // R7 directed: clear coinciding with a new edge, set wins
        cts_n_pin = 1'b0;
        step(); step();
        cts_chg_clr = 1'b1;
        step(); cts_chg_clr = 1'b0;
        step(); chk(cts_chg_flag, 1'b1, "R7 set beats clear");

        // Mixed random phases, compared every cycle
        for (int ph = 0; ph < 40; ph++) begin
            cts_en     = $urandom_range(0, 1);
            rts_en     = $urandom_range(0, 1);
            de_en      = $urandom_range(0, 1);
            de_pol_low = $urandom_range(0, 1);
            cts_irq_en = $urandom_range(0, 1);
            for (int c = 0; c < 150; c++) begin
                step();
                if ($urandom_range(0, 7) == 0) cts_n_pin = ~cts_n_pin;
                if ($urandom_range(0, 5) == 0) tx_pending = ~tx_pending;
                if ($urandom_range(0, 4) == 0) tx_busy = ~tx_busy;
                if ($urandom_range(0, 3) == 0) rx_space = ~rx_space;
                cts_chg_clr = ($urandom_range(0, 9) == 0);
            end
        end
        step();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule